// File: doc/BRIEF.md
# Four-Phase Trapezoidal Power-Clock Generator

This block produces the four staggered power-clock phases that a cycle-based model of pipelined adiabatic logic needs. A 2-bit period counter advances once per enabled system clock and steps through four equal periods: idle, evaluate, hold and recover. Each phase output is a symbolic three-level value. It is low while the phase is idle and high while it holds. Both ramps (evaluate and recover) use a separate intermediate level, so a ramp is never merged into a square wave.

Phase n is decoded from the counter plus n (modulo 4). Each phase therefore leads the previous one by a quarter period. This is the 90-degree stagger that lets one gate stage sample its input while the stage before it holds. Alongside each level, the block exports a one-hot period indicator, so downstream gate models can test which period is active without decoding levels. Each period lasts one enabled clock. With a 40 MHz clock, a 25 ns period and a 100 ns cycle result.

Top module: `quad_pclk_gen`

## Requirements
- R1: A synchronous active-high reset clears the counter to 0. After the reset edge, phase 0 is idle (level LOW, indicator 4'b0001).
- R2: On each rising clock edge with `en` high and `rst` low, the counter advances by one and wraps from 3 to 0. The period sequence of phase 0 is therefore idle, evaluate, hold, recover, idle, and so on.
- R3: The level codes are LOW = 2'b00 for idle, RAMP = 2'b01 for both evaluate and recover, and HIGH = 2'b10 for hold. The reserved code 2'b11 never appears on any phase.
- R4: Phase n uses the counter value plus n (modulo 4), so the indicator of phase n+1 is the indicator of phase n rotated left by one bit.
- R5: The period indicator of each phase is one-hot. Bit 0 is idle, bit 1 is evaluate, bit 2 is hold and bit 3 is recover. Phase n sits at `per_o[4n+3:4n]`, and its level sits at `lvl_o[2n+1:2n]`.
- R6: With `en` low and `rst` low, a clock edge leaves every level and indicator output unchanged.
- R7: Reset takes priority over enable. With `rst` and `en` both high, the counter returns to 0.
- R8: Each period lasts exactly one enabled clock cycle, so a full power-clock cycle takes four enabled cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the counter steps on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; low freezes the counter and all outputs |
| lvl_o | output | 8 | Level of each phase, 2 bits per phase, phase 0 in the low bits |
| per_o | output | 16 | One-hot period indicator of each phase, 4 bits per phase |

## Verification
The clocked properties assume that `rst` is asserted at the first clock edge, so the counter never holds an undefined value when a check is armed. They also assume `en` and `rst` are settled at each rising edge. The stimulus meets both assumptions: it raises reset from time zero and changes the inputs only on falling edges. The stimulus covers enabled runs across the wrap point, single-cycle and multi-cycle stalls, and reset asserted together with enable. This exercises both the hold behaviour and reset priority with the counter in a non-zero state.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    localparam int NUM_PHASES = 4;
    localparam int CNT_W      = 2;
    localparam int LVL_W      = 2;
    localparam int PER_W      = 1 << CNT_W;

    typedef enum logic [LVL_W-1:0] {
        LVL_LOW  = 2'b00,
        LVL_RAMP = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_BAD  = 2'b11
    } level_e;

    typedef enum logic [CNT_W-1:0] {
        PER_IDLE  = 2'd0,
        PER_EVAL  = 2'd1,
        PER_HOLD  = 2'd2,
        PER_RECOV = 2'd3
    } period_e;

    typedef struct packed {
        level_e           lvl;
        logic [PER_W-1:0] per;
    } phase_s;

    function automatic period_e period_of(input logic [CNT_W-1:0] c);
        return period_e'(c);
    endfunction

    function automatic level_e level_of(input period_e p);
        level_e l;
        case (p)
            PER_IDLE: l = LVL_LOW;
            PER_HOLD: l = LVL_HIGH;
            PER_EVAL,
            PER_RECOV: l = LVL_RAMP;
            default: l = LVL_BAD;
        endcase
        return l;
    endfunction

    function automatic logic [PER_W-1:0] onehot_of(input period_e p);
        logic [PER_W-1:0] v;
        v = '0;
        v[p] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/qpc_counter.sv
module qpc_counter
    import qpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/qpc_phase.sv
module qpc_phase
    import qpc_pkg::*;
#(
    parameter int PH_IDX = 0
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [LVL_W-1:0] lvl_o,
    output logic [PER_W-1:0] per_o
);

    localparam logic [CNT_W-1:0] OFFSET = CNT_W'(PH_IDX);

    logic [CNT_W-1:0] local_cnt;
    period_e          per_now;
    phase_s           ph;

    always_comb begin
        local_cnt = cnt_i + OFFSET;
        per_now   = period_of(local_cnt);
        ph.lvl    = level_of(per_now);
        ph.per    = onehot_of(per_now);
    end

    assign lvl_o = ph.lvl;
    assign per_o = ph.per;

endmodule

// File: rtl/quad_pclk_gen.sv
module quad_pclk_gen
    import qpc_pkg::*;
#(
    parameter int NUM_PH = NUM_PHASES
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    output logic [NUM_PH*LVL_W-1:0] lvl_o,
    output logic [NUM_PH*PER_W-1:0] per_o
);

    logic [CNT_W-1:0] cnt;

    qpc_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .cnt_o (cnt)
    );

    for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
        qpc_phase #(.PH_IDX(g)) u_ph (
            .cnt_i (cnt),
            .lvl_o (lvl_o[g*LVL_W +: LVL_W]),
            .per_o (per_o[g*PER_W +: PER_W])
        );
    end

endmodule

// File: rtl/qpc_chk.sv
module qpc_chk
    import qpc_pkg::*;
#(
    parameter int NUM_PH = NUM_PHASES
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    en,
    input logic [NUM_PH*LVL_W-1:0] lvl,
    input logic [NUM_PH*PER_W-1:0] per
);

    // R1: phase 0 is idle after a reset edge
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (per[PER_W-1:0] == 4'b0001 && lvl[LVL_W-1:0] == LVL_LOW));

    // R2 / R8: each enabled edge moves phase 0 exactly one period on
    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        en |=> per[PER_W-1:0] == {$past(per[PER_W-2:0]), $past(per[PER_W-1])});

    // R6: outputs frozen while enable is low
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(lvl) && $stable(per)));

    for (genvar g = 0; g < NUM_PH; g++) begin : g_ph
        // R5: indicator is one-hot
        a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
            $countones(per[g*PER_W +: PER_W]) == 1);
        // R3: reserved level never emitted
        a_r3_no_reserved: assert property (@(posedge clk) disable iff (rst)
            lvl[g*LVL_W +: LVL_W] != LVL_BAD);
        // R3: hold shows HIGH, idle shows LOW
        a_r3_hold_high: assert property (@(posedge clk) disable iff (rst)
            per[g*PER_W + 2] |-> lvl[g*LVL_W +: LVL_W] == LVL_HIGH);
        a_r3_idle_low: assert property (@(posedge clk) disable iff (rst)
            per[g*PER_W] |-> lvl[g*LVL_W +: LVL_W] == LVL_LOW);
    end

    for (genvar g = 0; g < NUM_PH - 1; g++) begin : g_stag
        // R4: next phase leads by one period
        a_r4_stagger: assert property (@(posedge clk) disable iff (rst)
            per[(g+1)*PER_W +: PER_W] ==
            {per[g*PER_W +: PER_W-1], per[g*PER_W + PER_W-1]});
    end

endmodule

bind quad_pclk_gen qpc_chk #(.NUM_PH(NUM_PH)) u_chk (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .lvl (lvl_o),
    .per (per_o)
);

// File: tb/quad_pclk_gen_tb.sv
`timescale 1ns/1ps
module quad_pclk_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [7:0]  lvl_o;
    logic [15:0] per_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    quad_pclk_gen u_dut (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .lvl_o (lvl_o),
        .per_o (per_o)
    );

    // entry: {rst, en, expected phase-0 count after the edge}
    localparam int NV = 16;
    localparam logic [3:0] VEC [NV] = '{
        {2'b10, 2'd0}, {2'b01, 2'd1}, {2'b01, 2'd2}, {2'b01, 2'd3},
        {2'b01, 2'd0}, {2'b00, 2'd0}, {2'b01, 2'd1}, {2'b00, 2'd1},
        {2'b00, 2'd1}, {2'b01, 2'd2}, {2'b11, 2'd0}, {2'b01, 2'd1},
        {2'b01, 2'd2}, {2'b01, 2'd3}, {2'b00, 2'd3}, {2'b10, 2'd0}
    };

    // R3/R4/R5: expected outputs from the phase-0 count
    function automatic logic [7:0] exp_lvl(input logic [1:0] c);
        logic [7:0] v;
        for (int n = 0; n < 4; n++) begin
            logic [1:0] k;
            k = c + 2'(n);
            v[2*n +: 2] = (k == 2'd0) ? 2'b00 : (k == 2'd2) ? 2'b10 : 2'b01;
        end
        return v;
    endfunction

    function automatic logic [15:0] exp_per(input logic [1:0] c);
        logic [15:0] v;
        for (int n = 0; n < 4; n++) begin
            logic [1:0] k;
            k = c + 2'(n);
            v[4*n +: 4] = 4'b0001 << k;
        end
        return v;
    endfunction

    task automatic check_cnt(input logic [1:0] c, input string tag);
        n_checks++;
        if (lvl_o !== exp_lvl(c)) begin
            n_fail++;
            $display("FAIL %s lvl_o actual=%b expected=%b", tag, lvl_o, exp_lvl(c));
        end
        n_checks++;
        if (per_o !== exp_per(c)) begin
            n_fail++;
            $display("FAIL %s per_o actual=%b expected=%b", tag, per_o, exp_per(c));
        end
    endtask

    task automatic step(input logic r, input logic e);
        @(negedge clk);
        rst = r;
        en  = e;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        string tag;
        logic [7:0]  snap_l;
        logic [15:0] snap_p;

        // R1: reset state
        step(1'b1, 1'b0);
        check_cnt(2'd0, "R1 reset");

        // table walk: R2 advance/wrap, R6 hold, R7 reset priority
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][3], VEC[i][2]);
            $sformat(tag, "R2/R6/R7 vector %0d", i);
            check_cnt(VEC[i][1:0], tag);
        end

        // R8: full cycle takes four enabled cycles and phase 0 returns to idle
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        check_cnt(2'd0, "R8 four-cycle period");

        // R3: reserved code never seen over a long run with stalls
        for (int i = 0; i < 12; i++) begin
            step(1'b0, (i % 3) != 0);
            for (int n = 0; n < 4; n++) begin
                n_checks++;
                if (lvl_o[2*n +: 2] === 2'b11) begin
                    n_fail++;
                    $display("FAIL R3 phase %0d actual=11 expected!=11", n);
                end
            end
        end

        // R6: long stall keeps outputs bit-identical
        snap_l = lvl_o;
        snap_p = per_o;
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
        n_checks++;
        if (lvl_o !== snap_l || per_o !== snap_p) begin
            n_fail++;
            $display("FAIL R6 stall actual=%b/%b expected=%b/%b",
                     lvl_o, per_o, snap_l, snap_p);
        end

        // R4/R5: phase 1 leads phase 0 by one period (field positions)
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        n_checks++;
        if (per_o[7:4] !== 4'b0100 || lvl_o[3:2] !== 2'b10) begin
            n_fail++;
            $display("FAIL R4 phase1 actual=%b/%b expected=0100/10",
                     per_o[7:4], lvl_o[3:2]);
        end
        check_cnt(2'd1, "R5 field layout");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule